// File: doc/BRIEF.md
# DDS Profile SPI Update Sequencer

This block pushes one set of filter results into a four-channel direct digital synthesizer. A single-cycle start strobe captures a frequency tuning word, a phase offset word and an amplitude scale factor. The block then runs a fixed timeline over SPI. An 8-bit command word selects the profile register and takes 16 system cycles. The 64-bit profile word follows and takes 128 system cycles. One idle cycle comes after that, and then a one-cycle IO-update pulse makes the synthesizer apply the new frequency, phase and amplitude at the same time.

Every bit takes two system cycles. SCLK is low in the first cycle of a bit and high in the second. Data changes only while SCLK is low, so the synthesizer samples it on the rising edge. Chip select stays low through the command and the profile with no gap between them. Once the IO-update pulse has ended, a one-cycle done strobe tells the filter pipeline that the next update may start. The duration of an update never changes, so the surrounding servo loop can plan its slots in advance.

Top module: `dds_profile_seq`

## Requirements
- R1: While rst_ni is low, and in idle after reset, spi_cs_n_o is 1 and spi_sclk_o, spi_sdo_o, io_update_o and done_o are 0. A start strobe that is asserted during reset has no effect.
- R2: start_i high in idle at a rising edge pulls spi_cs_n_o low from the next cycle onward, for exactly 144 consecutive cycles (16 command plus 128 profile).
- R3: During the frame each bit takes two cycles, SCLK 0 and then SCLK 1. spi_sdo_o does not change across the cycle in which SCLK is high.
- R4: The first 8 bits are the command word CMD_WORD (default 8'h0E), sent MSB first.
- R5: The next 64 bits are the profile word, sent MSB first. Bits 63:62 are 0, bits 61:48 are asf_i, bits 47:32 are pow_i and bits 31:0 are ftw_i.
- R6: The cycle right after the frame has spi_cs_n_o = 1, spi_sclk_o = 0, spi_sdo_o = 0 and io_update_o = 0 (the SPI wait).
- R7: io_update_o is high for exactly one cycle, in the cycle after the wait.
- R8: done_o is high for exactly one cycle, in the cycle after the IO-update pulse. A start in the following cycle is accepted at once.
- R9: A start strobe that arrives while a sequence is running, including the done cycle, is ignored. The timing of the running sequence does not change and no second frame begins.
- R10: ftw_i, pow_i and asf_i are captured when the start is accepted. Changes to them during the sequence do not alter the bits sent.
- R11: spi_sdo_o is 0 whenever spi_cs_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to send an update |
| ftw_i | input | 32 | Frequency tuning word |
| pow_i | input | 16 | Phase offset word |
| asf_i | input | 14 | Amplitude scale factor |
| spi_sclk_o | output | 1 | SPI clock, two system cycles per bit |
| spi_cs_n_o | output | 1 | SPI chip select, active low |
| spi_sdo_o | output | 1 | SPI serial data, MSB first |
| io_update_o | output | 1 | One-cycle pulse that applies the new settings |
| done_o | output | 1 | One-cycle pulse after the IO update |

## Verification
The profile fields are tried with four patterns, and each separates a different kind of fault. All zeros shows any stray one bit. All ones marks the field edges and proves that the two pad bits stay zero. Asymmetric alternating values catch swapped fields and bit reversal. Values with only the end bits set catch an off-by-one in the shift or the bit count. Directed cases cover the rest: a start pulse in the middle of a frame, a start pulse in the done cycle, input words that change during a transfer, and a start issued back to back right after done.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CMD  = 3'd1,
    PH_PROF = 3'd2,
    PH_WAIT = 3'd3,
    PH_IOUP = 3'd4,
    PH_DONE = 3'd5
  } phase_e;
endpackage

// File: rtl/dds_seq_packer.sv
module dds_seq_packer #(
  parameter int FTW_W  = 32,
  parameter int POW_W  = 16,
  parameter int ASF_W  = 14,
  parameter int PROF_W = 64
) (
  input  logic [FTW_W-1:0]  ftw_i,
  input  logic [POW_W-1:0]  pow_i,
  input  logic [ASF_W-1:0]  asf_i,
  output logic [PROF_W-1:0] word_o
);
  localparam int PAD_W = PROF_W - ASF_W - POW_W - FTW_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word_o = {{PAD_W{1'b0}}, asf_i, pow_i, ftw_i};
    end else begin : g_nopad
      assign word_o = {asf_i, pow_i, ftw_i};
    end
  endgenerate
endmodule

// File: rtl/dds_seq_ctrl.sv
module dds_seq_ctrl
  import dds_seq_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int PROF_W = 64
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output phase_e phase_o,
  output logic   half_o,
  output logic   load_o,
  output logic   shift_o
);
  localparam int MAX_W = (CMD_W > PROF_W) ? CMD_W : PROF_W;
  localparam int CNT_W = $clog2(MAX_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] PROF_LAST = CNT_W'(PROF_W - 1);

  phase_e           phase_q, phase_d;
  logic             half_q, half_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic             bit_last;

  // last bit of whichever phase is shifting
  assign bit_last = (phase_q == PH_CMD) ? (bit_q == CMD_LAST) : (bit_q == PROF_LAST);

  always_comb begin
    phase_d = phase_q;
    half_d  = half_q;
    bit_d   = bit_q;
    load_o  = 1'b0;
    shift_o = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_CMD;
          half_d  = 1'b0;
          bit_d   = '0;
          load_o  = 1'b1;
        end
      end
      PH_CMD, PH_PROF: begin
        half_d = ~half_q;
        if (half_q) begin
          shift_o = 1'b1;
          if (bit_last) begin
            bit_d   = '0;
            phase_d = (phase_q == PH_CMD) ? PH_PROF : PH_WAIT;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      PH_WAIT: phase_d = PH_IOUP;
      PH_IOUP: phase_d = PH_DONE;
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      half_q  <= 1'b0;
      bit_q   <= '0;
    end else begin
      phase_q <= phase_d;
      half_q  <= half_d;
      bit_q   <= bit_d;
    end
  end

  assign phase_o = phase_q;
  assign half_o  = half_q;
endmodule

// File: rtl/dds_seq_shifter.sv
module dds_seq_shifter #(
  parameter int W = 72
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] word_i,
  output logic         msb_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (load_i) begin
      sh_q <= word_i;
    end else if (shift_i) begin
      sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign msb_o = sh_q[W-1];
endmodule

// File: rtl/dds_profile_seq.sv
module dds_profile_seq
  import dds_seq_pkg::*;
#(
  parameter int               CMD_W    = 8,
  parameter logic [CMD_W-1:0] CMD_WORD = 8'h0E,
  parameter int               FTW_W    = 32,
  parameter int               POW_W    = 16,
  parameter int               ASF_W    = 14,
  parameter int               PROF_W   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [FTW_W-1:0] ftw_i,
  input  logic [POW_W-1:0] pow_i,
  input  logic [ASF_W-1:0] asf_i,
  output logic             spi_sclk_o,
  output logic             spi_cs_n_o,
  output logic             spi_sdo_o,
  output logic             io_update_o,
  output logic             done_o
);
  localparam int FRAME_W = CMD_W + PROF_W;

  phase_e              phase;
  logic                half, load, shift, msb, in_frame;
  logic [PROF_W-1:0]   prof_word;

  dds_seq_packer #(
    .FTW_W (FTW_W),
    .POW_W (POW_W),
    .ASF_W (ASF_W),
    .PROF_W(PROF_W)
  ) u_pack (
    .ftw_i (ftw_i),
    .pow_i (pow_i),
    .asf_i (asf_i),
    .word_o(prof_word)
  );

  dds_seq_ctrl #(
    .CMD_W (CMD_W),
    .PROF_W(PROF_W)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .phase_o(phase),
    .half_o (half),
    .load_o (load),
    .shift_o(shift)
  );

  dds_seq_shifter #(
    .W(FRAME_W)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .shift_i(shift),
    .word_i ({CMD_WORD, prof_word}),
    .msb_o  (msb)
  );

  assign in_frame    = (phase == PH_CMD) || (phase == PH_PROF);
  assign spi_cs_n_o  = ~in_frame;
  assign spi_sclk_o  = in_frame & half;
  assign spi_sdo_o   = in_frame & msb;
  assign io_update_o = (phase == PH_IOUP);
  assign done_o      = (phase == PH_DONE);
endmodule

// File: rtl/dds_profile_seq_chk.sv
module dds_profile_seq_chk #(
  parameter int FRAME_CYC = 144
) (
  input logic clk_i,
  input logic rst_ni,
  input logic spi_sclk_o,
  input logic spi_cs_n_o,
  input logic spi_sdo_o,
  input logic io_update_o,
  input logic done_o
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         low_cnt <= '0;
    else if (!spi_cs_n_o) low_cnt <= low_cnt + 1'b1;
    else                  low_cnt <= '0;
  end

  AST_FRAME_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_cs_n_o && low_cnt != 0) |-> low_cnt == 16'(FRAME_CYC)); // R2
  AST_FRAME_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt <= 16'(FRAME_CYC)); // R2
  AST_SCLK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spi_cs_n_o && !$past(spi_cs_n_o)) |-> spi_sclk_o != $past(spi_sclk_o)); // R3
  AST_SDO_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sclk_o |-> $stable(spi_sdo_o)); // R3
  AST_WAIT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_update_o |-> ($past(spi_cs_n_o) && !$past(spi_cs_n_o, 2) && !$past(io_update_o))); // R6
  AST_IOUP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_update_o |=> !io_update_o); // R7
  AST_DONE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_update_o |=> done_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && spi_cs_n_o)); // R9
  AST_SDO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_n_o |-> (!spi_sdo_o && !spi_sclk_o)); // R11
  AST_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!spi_cs_n_o, io_update_o, done_o})); // R7
endmodule

bind dds_profile_seq dds_profile_seq_chk #(
  .FRAME_CYC(2 * (CMD_W + PROF_W))
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .spi_sclk_o (spi_sclk_o),
  .spi_cs_n_o (spi_cs_n_o),
  .spi_sdo_o  (spi_sdo_o),
  .io_update_o(io_update_o),
  .done_o     (done_o)
);

// File: tb/dds_profile_seq_tb.sv
module dds_profile_seq_tb;
  localparam logic [7:0] CMD = 8'h0E;

  typedef struct packed {
    logic [31:0] ftw;
    logic [15:0] pw;
    logic [13:0] asf;
  } vec_t;

  // zeros, ones, asymmetric, end bits
  localparam vec_t VEC [4] = '{
    '{ftw: 32'h0000_0000, pw: 16'h0000, asf: 14'h0000},
    '{ftw: 32'hFFFF_FFFF, pw: 16'hFFFF, asf: 14'h3FFF},
    '{ftw: 32'hA5C3_0F69, pw: 16'h1234, asf: 14'h2AB5},
    '{ftw: 32'h8000_0001, pw: 16'h8001, asf: 14'h2001}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] ftw_i = '0;
  logic [15:0] pow_i = '0;
  logic [13:0] asf_i = '0;
  logic        spi_sclk_o, spi_cs_n_o, spi_sdo_o, io_update_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  dds_profile_seq u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ftw_i      (ftw_i),
    .pow_i      (pow_i),
    .asf_i      (asf_i),
    .spi_sclk_o (spi_sclk_o),
    .spi_cs_n_o (spi_cs_n_o),
    .spi_sdo_o  (spi_sdo_o),
    .io_update_o(io_update_o),
    .done_o     (done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // start is driven at the current point (between edges); sample n is cycle n of the frame
  task automatic run_frame(input vec_t v, input bit mutate, input bit poke_mid, input bit poke_done);
    logic [71:0] cap = '0;
    bit cs_ok = 1'b1, sck_ok = 1'b1, quiet_ok = 1'b1;
    ftw_i = v.ftw; pow_i = v.pw; asf_i = v.asf;
    start_i = 1'b1;
    for (int n = 0; n < 148; n++) begin
      @(negedge clk_i);
      if (n < 144) begin
        if (spi_cs_n_o !== 1'b0) cs_ok = 1'b0;
        if (spi_sclk_o !== 1'(n % 2)) sck_ok = 1'b0;
        if (io_update_o !== 1'b0 || done_o !== 1'b0) quiet_ok = 1'b0;
        if (n % 2 == 1) cap[71 - n / 2] = spi_sdo_o;
      end
      if (n == 144) begin
        chk(spi_cs_n_o === 1'b1 && spi_sclk_o === 1'b0, "R6", "wait cs/sclk",
            {62'd0, spi_cs_n_o, spi_sclk_o}, 64'h2);
        chk(io_update_o === 1'b0, "R6", "wait io_update", 64'(io_update_o), 64'h0);
        chk(spi_sdo_o === 1'b0, "R11", "sdo idle", 64'(spi_sdo_o), 64'h0);
      end
      if (n == 145) chk(io_update_o === 1'b1 && done_o === 1'b0, "R7", "io_update high",
                        {62'd0, io_update_o, done_o}, 64'h2);
      if (n == 146) chk(io_update_o === 1'b0 && done_o === 1'b1, "R8", "done high",
                        {62'd0, io_update_o, done_o}, 64'h1);
      if (n == 147) chk(done_o === 1'b0 && spi_cs_n_o === 1'b1, poke_done ? "R9" : "R8",
                        "after done", {62'd0, done_o, spi_cs_n_o}, 64'h1);
      // drives after sampling
      if (n == 0) start_i = 1'b0;
      if (mutate && n == 10) begin
        ftw_i = ~v.ftw; pow_i = ~v.pw; asf_i = ~v.asf;
      end
      if (poke_mid && n == 20) start_i = 1'b1;
      if (poke_mid && n == 21) start_i = 1'b0;
      if (poke_done && n == 146) start_i = 1'b1;
      if (n == 147) start_i = 1'b0;
    end
    chk(cs_ok, poke_mid ? "R9" : "R2", "cs_n low 144 cycles", 64'(cs_ok), 64'h1);
    chk(sck_ok, "R3", "sclk low-then-high per bit", 64'(sck_ok), 64'h1);
    chk(quiet_ok, "R7", "no io_update/done in frame", 64'(quiet_ok), 64'h1);
    chk(cap[71:64] == CMD, "R4", "command word", 64'(cap[71:64]), 64'(CMD));
    chk(cap[63:62] == 2'b00, "R5", "pad bits", 64'(cap[63:62]), 64'h0);
    chk(cap[61:48] == v.asf, mutate ? "R10" : "R5", "amplitude", 64'(cap[61:48]), 64'(v.asf));
    chk(cap[47:32] == v.pw, mutate ? "R10" : "R5", "phase", 64'(cap[47:32]), 64'(v.pw));
    chk(cap[31:0] == v.ftw, mutate ? "R10" : "R5", "frequency", 64'(cap[31:0]), 64'(v.ftw));
    if (poke_done) begin
      @(negedge clk_i);
      chk(spi_cs_n_o === 1'b1 && spi_sclk_o === 1'b0, "R9", "no frame from done-cycle start",
          {62'd0, spi_cs_n_o, spi_sclk_o}, 64'h2);
    end
  endtask

  initial begin
    // R1: reset state, start during reset ignored
    start_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(spi_cs_n_o === 1'b1 && spi_sclk_o === 1'b0 && spi_sdo_o === 1'b0 &&
        io_update_o === 1'b0 && done_o === 1'b0, "R1", "outputs in reset",
        {59'd0, spi_cs_n_o, spi_sclk_o, spi_sdo_o, io_update_o, done_o}, 64'h10);
    start_i = 1'b0;
    rst_ni  = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(spi_cs_n_o === 1'b1 && spi_sclk_o === 1'b0 && io_update_o === 1'b0 && done_o === 1'b0,
        "R1", "idle after reset", {60'd0, spi_cs_n_o, spi_sclk_o, io_update_o, done_o}, 64'h8);

    // table walk: R2..R8
    for (int i = 0; i < 4; i++) begin
      run_frame(VEC[i], 1'b0, 1'b0, 1'b0);
      @(negedge clk_i);
    end

    // R10: inputs change during the transfer
    run_frame(VEC[2], 1'b1, 1'b0, 1'b0);
    // R8: back-to-back start the cycle after done
    run_frame(VEC[3], 1'b0, 1'b0, 1'b0);
    // R9: start pulse mid frame and in the done cycle
    run_frame(VEC[2], 1'b0, 1'b1, 1'b1);
    @(negedge clk_i);
    chk(spi_cs_n_o === 1'b1 && spi_sdo_o === 1'b0, "R11", "idle sdo low",
        {62'd0, spi_cs_n_o, spi_sdo_o}, 64'h2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule